// File: doc/BRIEF.md
# Multi-core accelerator control register bank

This block is the software-facing control plane of a compute accelerator built from one to four cores. A host reaches it through a 32-bit AXI4-Lite slave port on its own clock with an active-low reset. Each core owns a 256-byte register window. The window holds a start flag, a 28-bit instruction page number and eight 40-bit base addresses, where each base address is split over a low and a high word. Two registers are shared by all cores: a reset mask and an interrupt status word.

The stored values drive per-core outputs directly. These are an active-high reset level, a one-cycle start pulse, a 40-bit instruction fetch address built from the page number, and a flat bus of base addresses. A one-cycle completion pulse from a core latches that core's status bit. The latched bit drives the matching line of an active-high interrupt vector. It stays latched until software withdraws the start flag or holds the core in reset.

Top module: `accel_ctrl_regs`

## Requirements
- R1: Every write gets BRESP=2'b00 and every read gets RRESP=2'b00. A read of an unmapped byte offset returns zero, and a write to one changes nothing. This includes offset 0x608 for writes, core windows at or above NUM_CORES, and any offset at 0x1000 or above.
- R2: The reset mask at offset 0x004 keeps bits [NUM_CORES-1:0] and reads zero above them. Bit n drives core_rst[n] from the cycle after the write handshake.
- R3: Core n's page register at offset 0x20C + 0x100·n keeps bits [27:0]. Bits [31:28] are dropped and read back as zero.
- R4: core_fetch_addr[40n+39:40n] equals the core n page field followed by twelve zero bits, so the fetch address is always 4 KiB aligned.
- R5: For base address k of core n (k = 0..7), the low word at 0x224 + 8k + 0x100·n keeps all 32 bits. The high word at 0x228 + 8k + 0x100·n keeps bits [7:0] and reads zero above them. The pair appears as {high[7:0], low} on core_base_addr[(8n+k)·40 +: 40].
- R6: Core n's start flag at 0x220 + 0x100·n keeps bit 0 only. A write that changes the flag from 0 to 1 gives exactly one one-cycle core_go[n] pulse, in the cycle after the write handshake. Rewriting 1 gives no further pulse.
- R7: A task_done[n] pulse sets bit n of the status word at 0x608 and irq[n] on the next clock edge. No other core's bit changes, so a core 1 completion alone reads 3'b010.
- R8: A status bit and its irq line stay set until a write leaves core n's start flag at 0, or while reset bit n is high. A clear coinciding with task_done[n] wins.
- R9: A write updates only the byte lanes whose s_wstrb bit is set. Lane i covers bits [8i+7:8i].
- R10: After reset, all registers read zero and core_rst, core_go and irq are all low.
- R11: Write and read handshakes are AXI4-Lite compliant. Address and data are accepted together, one transaction is outstanding per direction, and BVALID/RVALID with RDATA stay stable until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Register interface clock |
| cfg_rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte-lane enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| task_done | input | NUM_CORES | Per-core one-cycle completion pulse |
| core_rst | output | NUM_CORES | Per-core active-high reset level |
| core_go | output | NUM_CORES | Per-core one-cycle start pulse |
| core_fetch_addr | output | NUM_CORES*EXT_AW | Per-core 40-bit instruction fetch address |
| core_base_addr | output | NUM_CORES*BASE_CNT*EXT_AW | Per-core base addresses, core-major then index |
| irq | output | NUM_CORES | Per-core active-high interrupt |

## Verification
The hardest case to reach is a completion pulse that lands in the same edge as a write that withdraws that core's start flag. Here the priority between set and clear decides the result. The bench reaches it by raising task_done during the exact negedge-to-negedge slot of the write handshake. It also raises completion while the core's reset bit is held, so that the set path is blocked. Constrained-random traffic over mapped, absent-core and unmapped offsets, with random byte strobes, is checked against a bench-side register model. The fetch and base address buses are then compared with that model at the ports.

// File: rtl/acr_pkg.sv
`timescale 1ns/1ps
package acr_pkg;
   // shared register offsets (byte addresses)
   localparam logic [11:0] GLB_RESET_OFS  = 12'h004;
   localparam logic [11:0] GLB_STATUS_OFS = 12'h608;
   // address bits [11:8] of the window that belongs to core 0
   localparam int unsigned WIN_FIRST      = 2;
   // offsets inside a core window
   localparam logic [7:0]  LOC_PAGE       = 8'h0C;
   localparam logic [7:0]  LOC_START      = 8'h20;
   localparam logic [7:0]  LOC_BASE       = 8'h24;
   localparam logic [1:0]  RESP_OKAY      = 2'b00;

   function automatic logic [31:0] lane_mask(input logic [3:0] strb);
      for (int i = 0; i < 4; i++) lane_mask[i*8 +: 8] = {8{strb[i]}};
   endfunction

   function automatic logic [31:0] merge_lanes(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [31:0] mask);
      return (old_v & ~mask) | (new_v & mask);
   endfunction
endpackage

// File: rtl/acr_axil_port.sv
`timescale 1ns/1ps
module acr_axil_port import acr_pkg::*; #(
   parameter int AW = 12,
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   awaddr,
   input  logic            awvalid,
   output logic            awready,
   input  logic [DW-1:0]   wdata,
   input  logic [DW/8-1:0] wstrb,
   input  logic            wvalid,
   output logic            wready,
   output logic [1:0]      bresp,
   output logic            bvalid,
   input  logic            bready,
   input  logic [AW-1:0]   araddr,
   input  logic            arvalid,
   output logic            arready,
   output logic [DW-1:0]   rdata,
   output logic [1:0]      rresp,
   output logic            rvalid,
   input  logic            rready,
   output logic            wr_req,
   output logic [AW-1:0]   wr_addr,
   output logic [DW-1:0]   wr_data,
   output logic [DW/8-1:0] wr_strb,
   output logic [AW-1:0]   rd_addr,
   input  logic [DW-1:0]   rd_data
);
   localparam logic [AW-1:0] WORD_MASK = ~AW'(3);

   logic bvalid_q, rvalid_q;
   logic [DW-1:0] rdata_q;
   logic rd_fire;

   assign wr_req  = awvalid & wvalid & ~bvalid_q;
   assign awready = wr_req;
   assign wready  = wr_req;
   assign wr_addr = awaddr & WORD_MASK;
   assign wr_data = wdata;
   assign wr_strb = wstrb;

   assign arready = ~rvalid_q;
   assign rd_fire = arvalid & ~rvalid_q;
   assign rd_addr = araddr & WORD_MASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bvalid_q <= 1'b0;
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         if (wr_req)      bvalid_q <= 1'b1;
         else if (bready) bvalid_q <= 1'b0;
         if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_data;
         end else if (rready) begin
            rvalid_q <= 1'b0;
         end
      end
   end

   assign bvalid = bvalid_q;
   assign rvalid = rvalid_q;
   assign rdata  = rdata_q;
   assign bresp  = RESP_OKAY;
   assign rresp  = RESP_OKAY;

   // R11
   bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid && !bready |=> bvalid);
   // R11
   rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && !rready |=> rvalid && $stable(rdata));
endmodule

// File: rtl/acr_core_slot.sv
`timescale 1ns/1ps
module acr_core_slot import acr_pkg::*; #(
   parameter int DW    = 32,
   parameter int NBASE = 8,
   parameter int IAW   = 28,
   parameter int OUTW  = 40
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_hit,
   input  logic [7:0]            wr_off,
   input  logic [DW-1:0]         wr_data,
   input  logic [DW-1:0]         wr_mask,
   input  logic [7:0]            rd_off,
   input  logic                  core_rst,
   input  logic                  task_done,
   output logic [DW-1:0]         rd_data,
   output logic                  go,
   output logic [OUTW-1:0]       fetch_addr,
   output logic [NBASE*OUTW-1:0] base_flat,
   output logic                  done
);
   localparam int BHW     = OUTW - DW;
   localparam int PAGE_SH = OUTW - IAW;
   localparam logic [7:0] BASE_SPAN = 8'(8 * NBASE);

   logic [IAW-1:0] page_q;
   logic           start_q, start_d1, done_q;
   logic [DW-1:0]  page_nx, start_nx;
   logic           wr_page, wr_start, wr_base, rd_base;
   logic [7:0]     wr_rel, rd_rel;
   logic [NBASE-1:0][DW-1:0] rd_part;
   logic           clr;

   assign wr_page  = wr_hit && (wr_off == LOC_PAGE);
   assign wr_start = wr_hit && (wr_off == LOC_START);
   assign wr_rel   = wr_off - LOC_BASE;
   assign rd_rel   = rd_off - LOC_BASE;
   assign wr_base  = wr_hit && (wr_off >= LOC_BASE) && (wr_rel < BASE_SPAN);
   assign rd_base  = (rd_off >= LOC_BASE) && (rd_rel < BASE_SPAN);

   assign page_nx  = merge_lanes(DW'(page_q), wr_data, wr_mask);
   assign start_nx = merge_lanes(DW'(start_q), wr_data, wr_mask);
   assign clr      = core_rst || (wr_start && !start_nx[0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q   <= '0;
         start_q  <= 1'b0;
         start_d1 <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         start_d1 <= start_q;
         if (wr_page)  page_q  <= page_nx[IAW-1:0];
         if (wr_start) start_q <= start_nx[0];
         if (clr)            done_q <= 1'b0;
         else if (task_done) done_q <= 1'b1;
      end
   end

   for (genvar k = 0; k < NBASE; k++) begin : g_base
      logic [DW-1:0]  lo_q;
      logic [BHW-1:0] hi_q;
      logic [DW-1:0]  hi_nx, lo_nx;
      logic           sel;
      assign sel   = wr_base && ((wr_rel >> 3) == 8'(k));
      assign lo_nx = merge_lanes(lo_q, wr_data, wr_mask);
      assign hi_nx = merge_lanes(DW'(hi_q), wr_data, wr_mask);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (sel) begin
            if (wr_rel[2]) hi_q <= hi_nx[BHW-1:0];
            else           lo_q <= lo_nx;
         end
      end
      assign base_flat[k*OUTW +: OUTW] = {hi_q, lo_q};
      assign rd_part[k] = (rd_base && ((rd_rel >> 3) == 8'(k)))
                          ? (rd_rel[2] ? DW'(hi_q) : lo_q) : '0;
   end

   always_comb begin
      rd_data = '0;
      if (rd_off == LOC_PAGE)       rd_data = DW'(page_q);
      else if (rd_off == LOC_START) rd_data = DW'(start_q);
      else for (int k = 0; k < NBASE; k++) rd_data = rd_data | rd_part[k];
   end

   assign go         = start_q & ~start_d1;
   assign fetch_addr = {page_q, {PAGE_SH{1'b0}}};
   assign done       = done_q;

   // R6
   go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> !go);
   // R6
   go_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(go) |-> $past(wr_start));
endmodule

// File: rtl/accel_ctrl_regs.sv
`timescale 1ns/1ps
module accel_ctrl_regs import acr_pkg::*; #(
   parameter int NUM_CORES = 4,
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   parameter int BASE_CNT  = 8,
   parameter int INSTR_W   = 28,
   parameter int EXT_AW    = 40
) (
   input  logic                              cfg_clk,
   input  logic                              cfg_rst_n,
   input  logic [ADDR_W-1:0]                 s_awaddr,
   input  logic                              s_awvalid,
   output logic                              s_awready,
   input  logic [DATA_W-1:0]                 s_wdata,
   input  logic [DATA_W/8-1:0]               s_wstrb,
   input  logic                              s_wvalid,
   output logic                              s_wready,
   output logic [1:0]                        s_bresp,
   output logic                              s_bvalid,
   input  logic                              s_bready,
   input  logic [ADDR_W-1:0]                 s_araddr,
   input  logic                              s_arvalid,
   output logic                              s_arready,
   output logic [DATA_W-1:0]                 s_rdata,
   output logic [1:0]                        s_rresp,
   output logic                              s_rvalid,
   input  logic                              s_rready,
   input  logic [NUM_CORES-1:0]              task_done,
   output logic [NUM_CORES-1:0]              core_rst,
   output logic [NUM_CORES-1:0]              core_go,
   output logic [NUM_CORES*EXT_AW-1:0]       core_fetch_addr,
   output logic [NUM_CORES*BASE_CNT*EXT_AW-1:0] core_base_addr,
   output logic [NUM_CORES-1:0]              irq
);
   localparam int SLOT_BUS = BASE_CNT * EXT_AW;

   if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_bad_cores
      $error("NUM_CORES must lie in 1..4");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must be at least 12");
   end
   if (EXT_AW - DATA_W < 1 || EXT_AW - DATA_W > DATA_W || EXT_AW <= INSTR_W) begin : g_bad_ext
      $error("EXT_AW does not fit the split word layout");
   end
   if (BASE_CNT < 1 || BASE_CNT > 16) begin : g_bad_base
      $error("BASE_CNT must lie in 1..16");
   end

   logic                   wr_req;
   logic [ADDR_W-1:0]      wr_addr, rd_addr;
   logic [DATA_W-1:0]      wr_data, rd_data, wr_mask, rst_nx;
   logic [DATA_W/8-1:0]    wr_strb;
   logic                   wr_in_map, rd_in_map;
   logic [NUM_CORES-1:0]   rst_q, done_vec;
   logic [NUM_CORES-1:0][DATA_W-1:0] slot_rd;

   acr_axil_port #(.AW(ADDR_W), .DW(DATA_W)) u_port (
      .clk(cfg_clk), .rst_n(cfg_rst_n),
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
      .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
      .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
      .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   assign wr_mask   = lane_mask(wr_strb);
   assign wr_in_map = (wr_addr >> 12) == '0;
   assign rd_in_map = (rd_addr >> 12) == '0;
   assign rst_nx    = merge_lanes(DATA_W'(rst_q), wr_data, wr_mask);

   always_ff @(posedge cfg_clk) begin
      if (!cfg_rst_n) rst_q <= '0;
      else if (wr_req && wr_in_map && wr_addr[11:0] == GLB_RESET_OFS)
         rst_q <= rst_nx[NUM_CORES-1:0];
   end

   for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
      logic hit;
      assign hit = wr_req && wr_in_map && (wr_addr[11:8] == 4'(WIN_FIRST + n));
      acr_core_slot #(.DW(DATA_W), .NBASE(BASE_CNT), .IAW(INSTR_W), .OUTW(EXT_AW)) u_slot (
         .clk(cfg_clk), .rst_n(cfg_rst_n),
         .wr_hit(hit), .wr_off(wr_addr[7:0]), .wr_data(wr_data), .wr_mask(wr_mask),
         .rd_off(rd_addr[7:0]), .core_rst(rst_q[n]), .task_done(task_done[n]),
         .rd_data(slot_rd[n]), .go(core_go[n]),
         .fetch_addr(core_fetch_addr[n*EXT_AW +: EXT_AW]),
         .base_flat(core_base_addr[n*SLOT_BUS +: SLOT_BUS]),
         .done(done_vec[n])
      );

      // R7
      irq_rise_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
         $rose(irq[n]) |-> $past(task_done[n]));
      // R8
      rst_clears_irq_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
         core_rst[n] |=> !irq[n]);
   end

   always_comb begin
      rd_data = '0;
      if (rd_in_map) begin
         if (rd_addr[11:0] == GLB_RESET_OFS)       rd_data = DATA_W'(rst_q);
         else if (rd_addr[11:0] == GLB_STATUS_OFS) rd_data = DATA_W'(done_vec);
         else begin
            for (int n = 0; n < NUM_CORES; n++)
               if (rd_addr[11:8] == 4'(WIN_FIRST + n)) rd_data = slot_rd[n];
         end
      end
   end

   assign core_rst = rst_q;
   assign irq      = done_vec;

   // R2
   rst_follows_write_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      !$stable(core_rst) |-> $past(wr_req));
endmodule

// File: tb/accel_ctrl_regs_bench.sv
`timescale 1ns/1ps
module accel_ctrl_regs_bench;
   localparam int NC = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [11:0] awaddr = '0, araddr = '0;
   logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
   logic [31:0] wdata = '0;
   logic [3:0] wstrb = '0;
   logic awready, wready, bvalid, arready, rvalid;
   logic [1:0] bresp, rresp;
   logic [31:0] rdata;
   logic [NC-1:0] task_done = '0;
   logic [NC-1:0] core_rst, core_go, irq;
   logic [NC*40-1:0] core_fetch_addr;
   logic [NC*8*40-1:0] core_base_addr;

   accel_ctrl_regs #(.NUM_CORES(NC)) u_accel_ctrl_regs (
      .cfg_clk(clk), .cfg_rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(1'b1),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(1'b1),
      .task_done(task_done), .core_rst(core_rst), .core_go(core_go),
      .core_fetch_addr(core_fetch_addr), .core_base_addr(core_base_addr), .irq(irq)
   );

   int total = 0, bad = 0;
   int go_cnt [NC];

   // register model
   logic [NC-1:0] m_rst = '0, m_done = '0;
   logic [27:0] m_page [NC];
   logic        m_start [NC];
   logic [31:0] m_lo [NC][8];
   logic [7:0]  m_hi [NC][8];

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] lanes(input logic [3:0] s);
      logic [31:0] m;
      for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{s[i]}};
      return m;
   endfunction

   task automatic m_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
      logic [31:0] mk, t;
      logic [7:0] o, rel;
      int w, c, k;
      mk = lanes(s);
      w = int'(a[11:8]);
      o = a[7:0];
      if (a == 12'h004) begin
         t = ({29'b0, m_rst} & ~mk) | (d & mk);
         m_rst = t[NC-1:0];
         m_done = m_done & ~m_rst;
      end else if (w >= 2 && w < 2 + NC) begin
         c = w - 2;
         if (o == 8'h0C) begin
            t = ({4'b0, m_page[c]} & ~mk) | (d & mk);
            m_page[c] = t[27:0];
         end else if (o == 8'h20) begin
            t = ({31'b0, m_start[c]} & ~mk) | (d & mk);
            m_start[c] = t[0];
            if (!t[0]) m_done[c] = 1'b0;
         end else if (o >= 8'h24 && o < 8'h64) begin
            rel = o - 8'h24;
            k = int'(rel >> 3);
            if (rel[2]) begin
               t = ({24'b0, m_hi[c][k]} & ~mk) | (d & mk);
               m_hi[c][k] = t[7:0];
            end else begin
               m_lo[c][k] = (m_lo[c][k] & ~mk) | (d & mk);
            end
         end
      end
   endtask

   function automatic logic [31:0] m_rd(input logic [11:0] a);
      logic [7:0] o, rel;
      int w, c;
      w = int'(a[11:8]);
      o = a[7:0];
      if (a == 12'h004) return {29'b0, m_rst};
      if (a == 12'h608) return {29'b0, m_done};
      if (w >= 2 && w < 2 + NC) begin
         c = w - 2;
         if (o == 8'h0C) return {4'b0, m_page[c]};
         if (o == 8'h20) return {31'b0, m_start[c]};
         if (o >= 8'h24 && o < 8'h64) begin
            rel = o - 8'h24;
            if (rel[2]) return {24'b0, m_hi[c][int'(rel >> 3)]};
            return m_lo[c][int'(rel >> 3)];
         end
      end
      return 32'h0;
   endfunction

   function automatic string tag_of(input logic [11:0] a);
      if (a == 12'h004) return "R2";
      if (a == 12'h608) return "R7";
      if (a[11:8] >= 4'd2 && a[11:8] < 4'(2 + NC)) begin
         if (a[7:0] == 8'h0C) return "R3";
         if (a[7:0] == 8'h20) return "R6";
         if (a[7:0] >= 8'h24 && a[7:0] < 8'h64) return "R5";
      end
      return "R1";
   endfunction

   // write with an optional completion pulse in the same cycle
   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s,
                     input logic [NC-1:0] dn);
      @(negedge clk);
      awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1; task_done = dn;
      @(posedge clk);
      @(negedge clk);
      awvalid = 1'b0; wvalid = 1'b0; task_done = '0;
      for (int i = 0; i < NC; i++) if (dn[i] && !m_rst[i]) m_done[i] = 1'b1;
      m_wr(a, d, s);
      check("R11 bvalid", {63'b0, bvalid}, 64'd1);
      check("R1 bresp", {62'b0, bresp}, 64'd0);
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      araddr = a; arvalid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      arvalid = 1'b0;
      d = rdata;
      check("R11 rvalid", {63'b0, rvalid}, 64'd1);
      check("R1 rresp", {62'b0, rresp}, 64'd0);
   endtask

   task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      check(tag, {32'b0, d}, {32'b0, exp});
   endtask

   task automatic pulse_done(input logic [NC-1:0] dn);
      @(negedge clk);
      task_done = dn;
      @(negedge clk);
      task_done = '0;
      for (int i = 0; i < NC; i++) if (dn[i] && !m_rst[i]) m_done[i] = 1'b1;
   endtask

   function automatic logic [11:0] pick_addr();
      int r, w;
      r = $urandom_range(0, 9);
      w = $urandom_range(0, 3);
      case (r)
         0: return 12'h004;
         1: return 12'h608;
         2: return {4'(2 + w), 8'h0C};
         3: return {4'(2 + w), 8'h20};
         8: return {10'($urandom_range(0, 1023)), 2'b00};
         9: return {4'(2 + w), 8'(4 * $urandom_range(0, 63))};
         default: return {4'(2 + w), 8'h24 + 8'(4 * $urandom_range(0, 15))};
      endcase
   endfunction

   always @(negedge clk)
      if (rst_n) for (int i = 0; i < NC; i++) if (core_go[i]) go_cnt[i]++;

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [11:0] a;
      int g0;
      void'($urandom(32'd4242));
      for (int c = 0; c < NC; c++) begin
         go_cnt[c] = 0; m_page[c] = '0; m_start[c] = 1'b0;
         for (int k = 0; k < 8; k++) begin m_lo[c][k] = '0; m_hi[c][k] = '0; end
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      check("R10 irq", {61'b0, irq}, 64'd0);
      check("R10 core_go", {61'b0, core_go}, 64'd0);
      check("R10 core_rst", {61'b0, core_rst}, 64'd0);
      rd_chk("R10 page0", 12'h20C, 32'h0);
      rd_chk("R10 status", 12'h608, 32'h0);

      // R1 unmapped and absent-core windows
      rd_chk("R1 offset 0x100", 12'h100, 32'h0);
      wr(12'h524, 32'hFFFF_FFFF, 4'hF, '0);
      rd_chk("R1 absent core window", 12'h524, 32'h0);
      wr(12'h608, 32'hFFFF_FFFF, 4'hF, '0);
      rd_chk("R1 status is read-only", 12'h608, 32'h0);
      rd_chk("R1 offset 0x7FC", 12'h7FC, 32'h0);

      // R9 byte strobes
      wr(12'h224, 32'hFFFF_FFFF, 4'hF, '0);
      wr(12'h224, 32'h1234_5678, 4'b0101, '0);
      rd_chk("R9 lane merge", 12'h224, 32'hFF34_FF78);

      // R3 / R4 page register and fetch address
      wr(12'h20C, 32'hFABC_DEF1, 4'hF, '0);
      rd_chk("R3 upper bits dropped", 12'h20C, 32'h0ABC_DEF1);
      check("R4 fetch addr core0", {24'b0, core_fetch_addr[39:0]}, 64'h0A_BCDE_F100_0);

      // R5 high word of core1 base 7
      wr(12'h35C, 32'hCAFE_0001, 4'hF, '0);
      wr(12'h360, 32'hFFFF_FF5A, 4'hF, '0);
      rd_chk("R5 high word", 12'h360, 32'h0000_005A);
      check("R5 base bus core1 k7", {24'b0, core_base_addr[(1*8+7)*40 +: 40]}, 64'h5A_CAFE_0001);

      // R2 reset mask
      wr(12'h004, 32'hFFFF_FFFF, 4'hF, '0);
      rd_chk("R2 mask width", 12'h004, 32'h7);
      check("R2 core_rst", {61'b0, core_rst}, 64'h7);
      wr(12'h004, 32'h0, 4'hF, '0);
      check("R2 core_rst released", {61'b0, core_rst}, 64'h0);

      // R6 start pulse
      g0 = go_cnt[0];
      wr(12'h220, 32'h1, 4'hF, '0);
      repeat (3) @(negedge clk);
      check("R6 one pulse", 64'(go_cnt[0] - g0), 64'd1);
      check("R6 other cores quiet", 64'(go_cnt[1] + go_cnt[2]), 64'd0);
      wr(12'h220, 32'hFFFF_FFFF, 4'hF, '0);
      repeat (3) @(negedge clk);
      check("R6 held high no pulse", 64'(go_cnt[0] - g0), 64'd1);
      rd_chk("R6 start keeps bit0", 12'h220, 32'h1);
      wr(12'h220, 32'h0, 4'hF, '0);
      wr(12'h220, 32'h1, 4'hF, '0);
      repeat (2) @(negedge clk);
      check("R6 second rise", 64'(go_cnt[0] - g0), 64'd2);

      // R7 status and irq
      pulse_done(3'b010);
      check("R7 irq core1", {61'b0, irq}, 64'h2);
      rd_chk("R7 status core1 only", 12'h608, 32'h2);
      pulse_done(3'b001);
      rd_chk("R7 status two cores", 12'h608, 32'h3);

      // R8 clearing
      wr(12'h320, 32'h0, 4'hF, '0);
      check("R8 clear by start 0", {61'b0, irq}, 64'h1);
      wr(12'h004, 32'h1, 4'hF, '0);
      @(negedge clk);
      check("R8 clear by reset bit", {61'b0, irq}, 64'h0);
      pulse_done(3'b001);
      check("R8 done ignored in reset", {61'b0, irq}, 64'h0);
      wr(12'h004, 32'h0, 4'hF, '0);
      pulse_done(3'b100);
      check("R8 core2 set", {61'b0, irq}, 64'h4);
      wr(12'h420, 32'h1, 4'hF, '0);
      check("R8 start 1 keeps irq", {61'b0, irq}, 64'h4);
      wr(12'h420, 32'h0, 4'hF, 3'b100);
      check("R8 clear beats done", {61'b0, irq}, 64'h0);
      rd_chk("R8 status after collision", 12'h608, 32'h0);

      // random traffic against the model
      for (int i = 0; i < 400; i++) begin
         a = pick_addr();
         if ($urandom_range(0, 1) == 0) begin
            wr(a, $urandom(), 4'($urandom_range(0, 15)), '0);
         end else begin
            rd(a, d);
            check({tag_of(a), " random read"}, {32'b0, d}, {32'b0, m_rd(a)});
         end
      end
      @(negedge clk);
      check("R2 final core_rst", {61'b0, core_rst}, {61'b0, m_rst});
      for (int c = 0; c < NC; c++) begin
         check("R4 final fetch", {24'b0, core_fetch_addr[c*40 +: 40]}, {24'b0, m_page[c], 12'h000});
         for (int k = 0; k < 8; k++)
            check("R5 final base", {24'b0, core_base_addr[(c*8+k)*40 +: 40]},
                  {24'b0, m_hi[c][k], m_lo[c][k]});
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule